// File: doc/BRIEF.md
# Per-CPU Interrupt Claim Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers its best candidate: an ID, an 8-bit priority (lower number means more urgent) and, for software-raised IDs, the number of the CPU that raised it. The interface compares the candidate against a programmable threshold and against the priority of the interrupt the processor is already servicing. When the candidate beats both, it raises the request line.

The processor claims the interrupt by reading the claim register. That read returns the ID, pushes the candidate's priority onto a running-priority stack and sends a one-cycle claim pulse so the distributor can drop its pending bit. When service is done, software writes the same ID to the completion register. That pops the stack, restores the earlier running priority and sends a completion pulse to the distributor. If a claim read finds nothing qualifying, it returns the reserved ID 1023 and changes nothing.

Register map (2-bit word address): 0 control (bit 0 enables signalling), 1 priority threshold (bits 7:0), 2 claim (read only), 3 completion (write only). A write to address 2 is ignored. A read of address 3 returns zero.

Top module: `cpu_claim_if`

## Requirements
- R1: After reset the control register reads 0, the threshold reads 0, the request line is low and no interrupt is active.
- R2: While control bit 0 is clear, the request line stays low and a claim read returns 1023.
- R3: A candidate is signalled only when its priority is strictly below the threshold.
- R4: A candidate is signalled only when its priority is strictly below the priority of the most recently claimed active interrupt.
- R5: A claim read of a qualifying candidate returns its ID in bits 9:0, pulses claim_o with that ID in the same cycle, and makes its priority the running priority.
- R6: A claim read with no qualifying candidate returns 1023 in bits 9:0 with zero elsewhere, gives no claim pulse, and changes no state.
- R7: Candidate IDs 1021 to 1023 never qualify.
- R8: For candidate IDs 0 to 15, a claim read returns the source CPU number in bits 12:10. For other IDs those bits are zero.
- R9: A completion write whose bits 9:0 equal the most recently claimed active ID pulses done_o with that ID and restores the previous running priority.
- R10: A completion write with any other ID is ignored: no done_o pulse, and the running priority is unchanged.
- R11: When DEPTH interrupts are active, no candidate is signalled.
- R12: A read and a write in the same cycle perform the write only. The read has no claim side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cand_valid_i | input | 1 | Distributor offers a candidate |
| cand_id_i | input | 10 | Candidate interrupt ID |
| cand_prio_i | input | 8 | Candidate priority, lower is more urgent |
| cand_src_i | input | 3 | Source CPU of a software-raised candidate |
| reg_re_i | input | 1 | Register read strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address and state |
| irq_o | output | 1 | Interrupt request to the processor |
| claim_o | output | 1 | Claim pulse to the distributor |
| claim_id_o | output | 10 | ID being claimed |
| done_o | output | 1 | Completion pulse to the distributor |
| done_id_o | output | 10 | ID being completed |

## Verification
The bench goes after off-by-one comparisons. A candidate whose priority equals the threshold or the running priority must stay silent; a design that used a non-strict compare would raise the request line and allow same-level preemption. Completion writes with an ID that is not on top of the stack are targeted, because a design that popped on any completion write would lose the running priority and re-admit lower-priority work. The bench also covers a full stack, reserved IDs, reads that collide with writes, and the source-CPU field. A design that got these wrong would, respectively, overwrite a nested entry, hand out a reserved ID, or claim on a write cycle.

// File: rtl/cpu_claim_pkg.sv
package cpu_claim_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int SRC_W  = 3;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam logic [ID_W-1:0] MAX_ID      = 10'd1020;
  localparam logic [ID_W-1:0] SOFT_LAST   = 10'd15;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_MASK  = 2'd1,
    REG_CLAIM = 2'd2,
    REG_DONE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
  } active_t;
endpackage

// File: rtl/cpu_claim_cfg.sv
module cpu_claim_cfg
  import cpu_claim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic              en_o,
  output logic [PRIO_W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      mask_o <= '0;
    end else if (we_i) begin
      if (addr_i == REG_CTRL) en_o   <= wdata_i[0];
      if (addr_i == REG_MASK) mask_o <= wdata_i[PRIO_W-1:0];
    end
  end
endmodule

// File: rtl/cpu_claim_stack.sv
module cpu_claim_stack
  import cpu_claim_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  active_t           push_ent_i,
  input  logic              pop_i,
  output logic [PRIO_W-1:0] top_prio_o,
  output logic [ID_W-1:0]   top_id_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [CW-1:0]     depth_o
);
  active_t       ent_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] wr_idx, top_idx;

  assign wr_idx  = cnt_q[AW-1:0];
  assign top_idx = AW'(cnt_q - CW'(1));
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign depth_o = cnt_q;
  // empty stack: idle level, nothing preempted
  assign top_prio_o = empty_o ? '1 : ent_q[top_idx].prio;
  assign top_id_o   = empty_o ? SPURIOUS_ID : ent_q[top_idx].id;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (push_i && !full_o) begin
      ent_q[wr_idx] <= push_ent_i;
      cnt_q         <= cnt_q + CW'(1);
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/cpu_claim_select.sv
module cpu_claim_select
  import cpu_claim_pkg::*;
(
  input  logic              en_i,
  input  logic [PRIO_W-1:0] mask_i,
  input  logic [PRIO_W-1:0] run_prio_i,
  input  logic              full_i,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic [SRC_W-1:0]  cand_src_i,
  output logic              hit_o,
  output logic [31:0]       claim_word_o
);
  logic [SRC_W-1:0] src;

  assign hit_o = en_i && cand_valid_i && !full_i && (cand_id_i <= MAX_ID)
                 && (cand_prio_i < mask_i) && (cand_prio_i < run_prio_i);
  assign src   = (cand_id_i <= SOFT_LAST) ? cand_src_i : '0;
  assign claim_word_o = hit_o ? {19'd0, src, cand_id_i} : {22'd0, SPURIOUS_ID};
endmodule

// File: rtl/cpu_claim_if.sv
module cpu_claim_if
  import cpu_claim_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cand_valid_i,
  input  logic [9:0]  cand_id_i,
  input  logic [7:0]  cand_prio_i,
  input  logic [2:0]  cand_src_i,
  input  logic        reg_re_i,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o,
  output logic        claim_o,
  output logic [9:0]  claim_id_o,
  output logic        done_o,
  output logic [9:0]  done_id_o
);
  logic              cfg_en;
  logic [PRIO_W-1:0] cfg_mask;
  logic [PRIO_W-1:0] run_prio;
  logic [ID_W-1:0]   top_id;
  logic              stk_empty, stk_full;
  logic [CW-1:0]     depth;
  logic              hit;
  logic [31:0]       claim_word;
  logic              rd_claim, wr_done;

  cpu_claim_cfg u_cfg (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .en_o(cfg_en), .mask_o(cfg_mask)
  );

  cpu_claim_select u_sel (
    .en_i(cfg_en), .mask_i(cfg_mask), .run_prio_i(run_prio), .full_i(stk_full),
    .cand_valid_i, .cand_id_i, .cand_prio_i, .cand_src_i,
    .hit_o(hit), .claim_word_o(claim_word)
  );

  // a write in the same cycle suppresses the read side effect
  assign rd_claim   = reg_re_i && !reg_we_i && (reg_addr_i == REG_CLAIM);
  assign wr_done    = reg_we_i && (reg_addr_i == REG_DONE);
  assign claim_o    = rd_claim && hit;
  assign claim_id_o = cand_id_i;
  assign done_o     = wr_done && !stk_empty && (reg_wdata_i[ID_W-1:0] == top_id);
  assign done_id_o  = top_id;
  assign irq_o      = hit;

  cpu_claim_stack #(.DEPTH(DEPTH)) u_stk (
    .clk_i, .rst_ni,
    .push_i(claim_o), .push_ent_i('{id: cand_id_i, prio: cand_prio_i}),
    .pop_i(done_o),
    .top_prio_o(run_prio), .top_id_o(top_id),
    .empty_o(stk_empty), .full_o(stk_full), .depth_o(depth)
  );

  always_comb begin
    unique case (reg_addr_i)
      REG_CTRL:  reg_rdata_o = {31'd0, cfg_en};
      REG_MASK:  reg_rdata_o = {24'd0, cfg_mask};
      REG_CLAIM: reg_rdata_o = claim_word;
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cpu_claim_if_chk.sv
module cpu_claim_if_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_en,
  input logic [7:0]    cfg_mask,
  input logic [7:0]    run_prio,
  input logic [CW-1:0] depth,
  input logic [9:0]    cand_id_i,
  input logic [7:0]    cand_prio_i,
  input logic          reg_re_i,
  input logic          reg_we_i,
  input logic [1:0]    reg_addr_i,
  input logic [31:0]   reg_rdata_o,
  input logic          irq_o,
  input logic          claim_o,
  input logic          done_o
);
  // R2
  irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en |-> !irq_o);
  // R3
  below_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cand_prio_i < cfg_mask));
  // R4
  preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> (cand_prio_i < run_prio));
  // R5
  push_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |=> (run_prio == $past(cand_prio_i)));
  // R6
  spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && !reg_we_i && reg_addr_i == 2'd2 && !irq_o)
      |-> (reg_rdata_o == 32'd1023 && !claim_o));
  // R7
  reserved_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cand_id_i <= 10'd1020));
  // R9
  pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (depth == $past(depth) - CW'(1)));
  // R11
  full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth == CW'(DEPTH)) |-> !irq_o);
  // R12
  collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |-> !claim_o);
endmodule

bind cpu_claim_if cpu_claim_if_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_en(cfg_en), .cfg_mask(cfg_mask),
  .run_prio(run_prio), .depth(depth), .cand_id_i(cand_id_i),
  .cand_prio_i(cand_prio_i), .reg_re_i(reg_re_i), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
  .claim_o(claim_o), .done_o(done_o)
);

// File: tb/cpu_claim_if_tb_top.sv
`timescale 1ns/1ps
module cpu_claim_if_tb_top;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cand_valid_i = 1'b0;
  logic [9:0]  cand_id_i = '0;
  logic [7:0]  cand_prio_i = '0;
  logic [2:0]  cand_src_i = '0;
  logic        reg_re_i = 1'b0, reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, claim_o, done_o;
  logic [9:0]  claim_id_o, done_id_o;

  int checks = 0, errors = 0;
  bit ended = 0;

  // reference model
  bit       m_en;
  int       m_mask;
  int       m_cnt;
  int       m_id [DEPTH];
  int       m_pr [DEPTH];

  always #4 clk = ~clk;

  cpu_claim_if #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni, .cand_valid_i, .cand_id_i, .cand_prio_i, .cand_src_i,
    .reg_re_i, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .irq_o, .claim_o, .claim_id_o, .done_o, .done_id_o
  );

  function automatic int run_prio();
    return (m_cnt == 0) ? 255 : m_pr[m_cnt-1];
  endfunction

  function automatic bit exp_hit(bit v, int id, int pr);
    return m_en && v && id <= 1020 && pr < m_mask && pr < run_prio() && m_cnt < DEPTH;
  endfunction

  function automatic int exp_word(bit v, int id, int pr, int src);
    if (!exp_hit(v, id, pr)) return 1023;
    return ((id <= 15 ? src : 0) << 10) | id;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus cycle; outputs sampled mid-low-phase, model advanced as the edge would
  task automatic step(bit re, bit we, int addr, int wd, bit v, int id, int pr, int src,
                      string req);
    bit h, d;
    @(negedge clk);
    reg_re_i = re; reg_we_i = we; reg_addr_i = 2'(addr); reg_wdata_i = 32'(wd);
    cand_valid_i = v; cand_id_i = 10'(id); cand_prio_i = 8'(pr); cand_src_i = 3'(src);
    #2;
    h = exp_hit(v, id, pr);
    chk(req, irq_o, h);
    if (re && !we && addr == 2) begin
      chk(req, reg_rdata_o, exp_word(v, id, pr, src));
      chk(req, claim_o, h);
      if (h) chk(req, claim_id_o, id);
    end else if (re && addr == 0) chk(req, reg_rdata_o, m_en);
    else if (re && addr == 1) chk(req, reg_rdata_o, m_mask);
    if (we) chk(req, claim_o, 0);
    d = we && addr == 3 && m_cnt > 0 && (wd & 1023) == m_id[m_cnt-1];
    if (we && addr == 3) begin
      chk(req, done_o, d);
      if (d) chk(req, done_id_o, m_id[m_cnt-1]);
    end
    if (we) begin
      if (addr == 0) m_en = wd[0];
      if (addr == 1) m_mask = wd & 255;
      if (d) m_cnt--;
    end else if (re && addr == 2 && h) begin
      m_id[m_cnt] = id; m_pr[m_cnt] = pr; m_cnt++;
    end
  endtask

  task automatic idle(bit v, int id, int pr, string req);
    step(0, 0, 0, 0, v, id, pr, 0, req);
  endtask

  initial begin
    #1_000_000;
    if (!ended) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_en = 0; m_mask = 0; m_cnt = 0;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 0, 1, 0, 1, 50, 0, 0, "R1");
    step(1, 0, 2, 0, 1, 50, 0, 0, "R6");
    // R2 disabled
    step(0, 1, 1, 'h80, 0, 0, 0, 0, "R3");
    step(1, 0, 2, 0, 1, 60, 'h10, 0, "R2");
    step(0, 1, 0, 1, 0, 0, 0, 0, "R2");
    // R3 strict threshold
    idle(1, 60, 'h80, "R3");
    idle(1, 60, 'h7f, "R3");
    // R5 claim
    step(1, 0, 2, 0, 1, 40, 'h50, 0, "R5");
    // R4 strict preemption
    idle(1, 41, 'h50, "R4");
    idle(1, 41, 'h4f, "R4");
    // R10 wrong completion ID
    step(0, 1, 3, 7, 0, 0, 0, 0, "R10");
    idle(1, 41, 'h50, "R10");
    idle(1, 41, 'h4f, "R10");
    // R12 read and write together
    step(1, 1, 2, 0, 1, 41, 'h10, 0, "R12");
    // R8 software source field
    step(1, 0, 2, 0, 1, 5, 'h10, 3, "R8");
    step(1, 0, 2, 0, 1, 16, 'h08, 6, "R8");
    // R7 reserved IDs
    idle(1, 1021, 0, "R7");
    idle(1, 1023, 0, "R7");
    // R9 completion order
    step(0, 1, 3, 16, 0, 0, 0, 0, "R9");
    step(0, 1, 3, 5, 0, 0, 0, 0, "R9");
    idle(1, 41, 'h20, "R9");
    step(0, 1, 3, 40, 0, 0, 0, 0, "R9");
    idle(1, 41, 'h60, "R9");
    // R11 full stack
    for (int i = 0; i < DEPTH; i++) step(1, 0, 2, 0, 1, 100 + i, 'h40 - 16*i, 0, "R11");
    idle(1, 200, 'h01, "R11");
    step(1, 0, 2, 0, 1, 200, 'h01, 0, "R11");
    for (int i = DEPTH - 1; i >= 0; i--) step(0, 1, 3, 100 + i, 0, 0, 0, 0, "R9");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      int id = ($urandom_range(0, 9) == 0) ? $urandom_range(1018, 1023) : $urandom_range(0, 40);
      int pr = $urandom_range(0, 255);
      int src = $urandom_range(0, 7);
      bit v = $urandom_range(0, 7) != 0;
      if (r < 40) step(1, 0, 2, 0, v, id, pr, src, "R5");
      else if (r < 55) step(0, 1, 3, (m_cnt > 0 && r < 50) ? m_id[m_cnt-1] : $urandom_range(0, 40),
                           v, id, pr, src, "R9");
      else if (r < 60) step(0, 1, 1, $urandom_range(0, 255), v, id, pr, src, "R3");
      else if (r < 62) step(0, 1, 0, $urandom_range(0, 3) != 0, v, id, pr, src, "R2");
      else if (r < 64) step(1, 1, 2, 0, v, id, pr, src, "R12");
      else if (r < 70) step(1, 0, $urandom_range(0, 1), 0, v, id, pr, src, "R1");
      else idle(v, id, pr, "R4");
    end

    ended = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule